// File: doc/BRIEF.md
# Doorbell Range Match and Wake

This block watches doorbell writes and reacts to each one in two separate ways. First, it compares the doorbell dword address against a programmable lower and upper bound. An address inside that window sets a sticky flag, and the flag wakes an idle scheduler and keeps the power-gating controller from shutting the engine down. The flag stays set until the scheduler clears it. Second, the block compares the full address against a small table of queue-slot doorbell addresses. For the matching slot it issues a one-cycle start request.

The bounds do not gate slot matching. In the default mode the range test uses the whole dword address. A mode bit narrows the range test to the offset within a 4 KB page, which is address bits [9:0]. The upper address bits can then carry a process identifier without disturbing the range test. Slot matching always compares every address bit.

Software programs the bounds, the mode, the slot enables and the slot addresses through a plain write port. Each register is selected by an index.

Top module: `dbw_range_wake`

## Requirements
- R1: After reset the lower bound is 0x12 and the upper bound is 0x3FFFFF. The compare mode is full-address, every slot is disabled, and wake_o and slot_start_o are 0.
- R2: In full mode, a doorbell whose address satisfies lower <= addr <= upper sets the updated flag. The test is inclusive at both bounds.
- R3: A doorbell outside the window does not set the flag. For example, with the upper bound at dword 0x400 (byte 4 KB), a doorbell at dword 0x600 (byte 6 KB) leaves wake_o at 0.
- R4: When mode bit 0 is 1, the range test compares only address bits [9:0] against bits [9:0] of both bounds. Bits above bit 9 are ignored by the range test.
- R5: The flag is sticky until a wake_clr pulse clears it. If a setting doorbell and wake_clr arrive in the same cycle, the flag ends up set.
- R6: wake_o is the flag register itself. It changes on the first clock edge that samples the doorbell or the clear, and not before that edge.
- R7: A doorbell whose full address equals the address of an enabled slot drives that slot's bit of slot_start_o high for one cycle. This happens whether or not the address is inside the range window. Disabled slots never start.
- R8: When several enabled slots match, only the lowest-numbered one is started. At most one bit of slot_start_o is high at a time, and it falls in the next cycle unless another matching doorbell arrives.
- R9: The register indices on cfg_sel are as follows. A write takes effect at the clock edge on which it is sampled.

  | cfg_sel | Register |
  |---|---|
  | 0 | lower bound |
  | 1 | upper bound |
  | 2 | mode (bit 0: 1 = page offset) |
  | 3 | slot enables (bit i enables slot i) |
  | 4+i | address of slot i |
- R10: Slot matching compares all address bits in both modes. In page mode, an address that differs from a slot address only above bit 9 does not start that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| db_valid | input | 1 | Doorbell write strobe, one cycle per doorbell |
| db_addr | input | ADDR_W (26) | Doorbell dword address (byte address bits 27:2) |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | SEL_W (4) | Register index |
| cfg_wdata | input | DATA_W (32) | Register write data |
| wake_clr | input | 1 | Clears the updated flag |
| wake_o | output | 1 | Updated flag: wakes the scheduler and blocks power gating |
| slot_start_o | output | NUM_SLOTS (8) | One-cycle start request, one bit per queue slot |

## Verification
The bench builds the block with its default parameters: a 26-bit dword address, a 10-bit page offset and eight slots. With these values the exact reset bounds 0x12 and 0x3FFFFF can be probed one below and one above each bound.

The ten-bit offset lets the bench put a process identifier above bit 9 and show the range test ignoring it in page mode. Slot matching still sees that identifier.

With eight slots, the bench can program duplicate slot addresses at slots 2 and 5 and a third slot at index 0. This exercises the lowest-index priority and the effect of clearing an enable.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
  localparam int unsigned REG_LOWER     = 0;
  localparam int unsigned REG_UPPER     = 1;
  localparam int unsigned REG_MODE      = 2;
  localparam int unsigned REG_ENABLE    = 3;
  localparam int unsigned REG_SLOT_BASE = 4;

  typedef enum logic {
    CMP_FULL = 1'b0,
    CMP_PAGE = 1'b1
  } cmp_mode_e;
endpackage

// File: rtl/dbw_cfg_regs.sv
module dbw_cfg_regs
  import dbw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 26,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SEL_W     = 4,
  parameter logic [ADDR_W-1:0] LOWER_RST = 'h12,
  parameter logic [ADDR_W-1:0] UPPER_RST = 'h3FFFFF
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [SEL_W-1:0]                    cfg_sel,
  input  logic [DATA_W-1:0]                   cfg_wdata,
  output logic [ADDR_W-1:0]                   lower_q,
  output logic [ADDR_W-1:0]                   upper_q,
  output cmp_mode_e                           mode_q,
  output logic [NUM_SLOTS-1:0]                en_q,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]    slot_addr_q
);
  logic                 lower_en, upper_en, mode_en, enab_en;
  logic [ADDR_W-1:0]    addr_d;
  cmp_mode_e            mode_d;
  logic [NUM_SLOTS-1:0] en_d;
  logic [NUM_SLOTS-1:0] slot_en;

  // next-state and write-enable decode
  always_comb begin
    lower_en = cfg_we && (cfg_sel == SEL_W'(REG_LOWER));
    upper_en = cfg_we && (cfg_sel == SEL_W'(REG_UPPER));
    mode_en  = cfg_we && (cfg_sel == SEL_W'(REG_MODE));
    enab_en  = cfg_we && (cfg_sel == SEL_W'(REG_ENABLE));
    addr_d   = cfg_wdata[ADDR_W-1:0];
    mode_d   = cmp_mode_e'(cfg_wdata[0]);
    en_d     = cfg_wdata[NUM_SLOTS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lower_q <= LOWER_RST;
      upper_q <= UPPER_RST;
      mode_q  <= CMP_FULL;
      en_q    <= '0;
    end else begin
      if (lower_en) lower_q <= addr_d;
      if (upper_en) upper_q <= addr_d;
      if (mode_en)  mode_q  <= mode_d;
      if (enab_en)  en_q    <= en_d;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_en[g] = cfg_we && (cfg_sel == SEL_W'(REG_SLOT_BASE + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_addr_q[g] <= '0;
      else if (slot_en[g]) slot_addr_q[g] <= addr_d;
    end
  end
endmodule

// File: rtl/dbw_range_check.sv
module dbw_range_check
  import dbw_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned OFFS_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lower,
  input  logic [ADDR_W-1:0] upper,
  input  cmp_mode_e         mode,
  output logic              in_range
);
  logic full_hit, page_hit;

  always_comb begin
    full_hit = (addr >= lower) && (addr <= upper);
    page_hit = (addr[OFFS_W-1:0] >= lower[OFFS_W-1:0]) &&
               (addr[OFFS_W-1:0] <= upper[OFFS_W-1:0]);
    in_range = (mode == CMP_PAGE) ? page_hit : full_hit;
  end
endmodule

// File: rtl/dbw_slot_match.sv
module dbw_slot_match #(
  parameter int unsigned ADDR_W    = 26,
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             db_valid,
  input  logic [ADDR_W-1:0]                db_addr,
  input  logic [NUM_SLOTS-1:0]             en,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr,
  output logic [NUM_SLOTS-1:0]             start_q
);
  logic [NUM_SLOTS-1:0] hit;
  logic [NUM_SLOTS-1:0] grant;
  logic [NUM_SLOTS-1:0] start_d;
  logic                 found;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
    assign hit[g] = en[g] && (slot_addr[g] == db_addr);
  end

  // lowest index wins
  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (hit[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    start_d = db_valid ? grant : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= '0;
    else        start_q <= start_d;
  end
endmodule

// File: rtl/dbw_wake_flag.sv
module dbw_wake_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  logic flag_d;

  always_comb flag_d = set | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/dbw_range_wake.sv
module dbw_range_wake
  import dbw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 26,
  parameter int unsigned OFFS_W    = 10,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] LOWER_RST = 'h12,
  parameter logic [ADDR_W-1:0] UPPER_RST = 'h3FFFFF,
  localparam int unsigned SEL_W = $clog2(REG_SLOT_BASE + NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 db_valid,
  input  logic [ADDR_W-1:0]    db_addr,
  input  logic                 cfg_we,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic                 wake_clr,
  output logic                 wake_o,
  output logic [NUM_SLOTS-1:0] slot_start_o
);
  logic [1:0]                       rst_pipe;
  logic                             rst_int_n;
  logic [ADDR_W-1:0]                lower_q, upper_q;
  cmp_mode_e                        mode_q;
  logic [NUM_SLOTS-1:0]             en_q;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr_q;
  logic                             in_range;
  logic                             wake_set;

  // async assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  dbw_cfg_regs #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .SEL_W(SEL_W),
    .LOWER_RST(LOWER_RST), .UPPER_RST(UPPER_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .lower_q(lower_q), .upper_q(upper_q),
    .mode_q(mode_q), .en_q(en_q), .slot_addr_q(slot_addr_q)
  );

  dbw_range_check #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_range (
    .addr(db_addr), .lower(lower_q), .upper(upper_q), .mode(mode_q),
    .in_range(in_range)
  );

  assign wake_set = db_valid && in_range;

  dbw_wake_flag u_flag (
    .clk(clk), .rst_n(rst_int_n), .set(wake_set), .clr(wake_clr),
    .flag_q(wake_o)
  );

  dbw_slot_match #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_int_n), .db_valid(db_valid), .db_addr(db_addr),
    .en(en_q), .slot_addr(slot_addr_q), .start_q(slot_start_o)
  );
endmodule

// File: rtl/dbw_range_wake_chk.sv
module dbw_range_wake_chk #(
  parameter int unsigned NUM_SLOTS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 db_valid,
  input logic                 wake_clr,
  input logic                 wake_o,
  input logic [NUM_SLOTS-1:0] slot_start_o
);
  assert_start_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_start_o));

  assert_no_ring_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !db_valid |=> (slot_start_o == '0));

  assert_wake_needs_ring_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!db_valid && !wake_o) |=> !wake_o);

  assert_wake_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o && !wake_clr) |=> wake_o);

  assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_clr && !db_valid) |=> !wake_o);
endmodule

bind dbw_range_wake dbw_range_wake_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .wake_clr(wake_clr),
  .wake_o(wake_o), .slot_start_o(slot_start_o)
);

// File: tb/test_dbw_range_wake.sv
module test_dbw_range_wake;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 26;
  localparam int NS = 8;
  localparam int SW = 4;

  typedef struct {
    logic          wake;
    logic [NS-1:0] start;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          db_valid;
  logic [AW-1:0] db_addr;
  logic          cfg_we;
  logic [SW-1:0] cfg_sel;
  logic [31:0]   cfg_wdata;
  logic          wake_clr;
  logic          wake_o;
  logic [NS-1:0] slot_start_o;

  int checks = 0;
  int fails  = 0;
  exp_t exp_q[$];

  // bench-side model of the programmed state
  logic [AW-1:0] m_lo = 'h12, m_hi = 'h3FFFFF;
  logic          m_page = 1'b0;
  logic [NS-1:0] m_en = '0;
  logic [AW-1:0] m_slot [NS];
  logic          m_wake = 1'b0;

  dbw_range_wake i_dbw_range_wake (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_addr(db_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .wake_clr(wake_clr), .wake_o(wake_o), .slot_start_o(slot_start_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic in_win(logic [AW-1:0] a);
    if (m_page) return (a[9:0] >= m_lo[9:0]) && (a[9:0] <= m_hi[9:0]);
    return (a >= m_lo) && (a <= m_hi);
  endfunction

  function automatic logic [NS-1:0] exp_start(logic [AW-1:0] a);
    for (int i = 0; i < NS; i++)
      if (m_en[i] && m_slot[i] == a) return NS'(1) << i;
    return '0;
  endfunction

  task automatic step(input logic v, input logic [AW-1:0] a, input logic c, input string tag);
    exp_t e;
    @(negedge clk);
    db_valid = v; db_addr = a; wake_clr = c; cfg_we = 1'b0;
    m_wake  = (v && in_win(a)) | (m_wake & ~c);
    e.wake  = m_wake;
    e.start = v ? exp_start(a) : '0;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic cfg_write(input int sel, input logic [31:0] d);
    exp_t e;
    @(negedge clk);
    db_valid = 1'b0; wake_clr = 1'b0;
    cfg_we = 1'b1; cfg_sel = SW'(sel); cfg_wdata = d;
    e.wake = m_wake; e.start = '0; e.tag = "R9 cfg write";
    exp_q.push_back(e);
    case (sel)
      0: m_lo = d[AW-1:0];
      1: m_hi = d[AW-1:0];
      2: m_page = d[0];
      3: m_en = d[NS-1:0];
      default: m_slot[sel-4] = d[AW-1:0];
    endcase
  endtask

  // monitor: one expected item per clock edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (wake_o !== e.wake || slot_start_o !== e.start) begin
          fails++;
          $display("FAIL %s: wake=%0b exp=%0b start=%b exp=%b",
                   e.tag, wake_o, e.wake, slot_start_o, e.start);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) m_slot[i] = '0;
    rst_n = 1'b0; db_valid = 1'b0; db_addr = '0; cfg_we = 1'b0;
    cfg_sel = '0; cfg_wdata = '0; wake_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (wake_o !== 1'b0 || slot_start_o !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs: wake=%0b start=%b exp 0", wake_o, slot_start_o);
    end

    // R1 reset bounds and disabled slots
    step(1, 'h0,      0, "R1 slots disabled, below lower");
    step(1, 'h11,     0, "R1 one below reset lower");
    step(1, 'h12,     0, "R1 reset lower inclusive");
    step(0, 'h0,      1, "R5 clear");
    step(1, 'h3FFFFF, 0, "R1 reset upper inclusive");
    step(0, 'h0,      1, "R5 clear");
    step(1, 'h400000, 0, "R1 one above reset upper");

    // R2 / R3 programmed window
    cfg_write(0, 'h100);
    cfg_write(1, 'h400);
    step(1, 'h100, 0, "R2 lower bound hit");
    step(0, 'h0,   1, "R5 clear");
    step(1, 'h400, 0, "R2 upper bound hit");
    step(0, 'h0,   1, "R5 clear");
    step(1, 'h600, 0, "R3 6KB beyond 4KB upper");
    step(1, 'hFF,  0, "R3 below lower");

    // R5 / R6 sticky behaviour
    step(1, 'h200, 0, "R6 wake one edge after ring");
    step(0, 'h0,   0, "R5 flag holds");
    step(1, 'h201, 1, "R5 set wins over clear");
    step(0, 'h0,   1, "R5 clear drops flag");

    // R4 page-offset mode
    cfg_write(0, 'h010);
    cfg_write(1, 'h020);
    step(1, 'h7015, 0, "R4 full mode ignores offset-only fit");
    cfg_write(2, 'h1);
    step(1, (26'h1234 << 10) | 26'h015, 0, "R4 page mode hit with id bits");
    step(0, 'h0, 1, "R5 clear");
    step(1, (26'h5 << 10) | 26'h030, 0, "R4 page mode offset outside");

    // R7 / R8 / R10 slot matching
    cfg_write(4 + 2, 'hABC);
    cfg_write(4 + 5, 'hABC);
    cfg_write(4 + 0, 'h1000015);
    cfg_write(3, 'b0010_0101);
    step(1, 'hABC, 0, "R8 lowest matching slot wins");
    step(0, 'h0,   0, "R8 start lasts one cycle");
    cfg_write(3, 'b0010_0001);
    step(1, 'hABC, 0, "R7 disabled slot skipped, out of range still starts");
    step(1, 'h1000015, 0, "R7 full match with range hit");
    step(0, 'h0, 1, "R5 clear");
    step(1, 'h0000015, 0, "R10 offset alias does not start slot");
    step(0, 'h0, 1, "R5 clear");
    step(0, 'h0, 0, "idle");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule